// File: doc/BRIEF.md
# 8b/10b Transmit Encoder with Disparity Override

This block turns one byte per clock into a 10-bit DC-balanced line code group. A control flag beside the byte selects between the data alphabet and the small set of control (special) characters. The encoder tracks the running disparity from word to word and picks, for every sub-block, the variant that keeps the line balanced.

On any word the caller may take over the disparity choice. When the override flag is set, the word is encoded as if the running disparity were the one given on a separate value input. The tracked disparity then continues from the code group that was actually sent. A polarity control complements every bit of the emitted code group. This serves links whose differential pair is swapped on the board. Serialization and lane packing are done by logic downstream.

Top module: `tx8b10b_enc`

## Requirements
- R1: With `ctrl_i` = 0, the byte is encoded as a data code group using the standard 8b/10b 5b/6b and 3b/4b mapping. Sub-block x is `byte_i[4:0]` and y is `byte_i[7:5]`. `cg_o[5:0]` carries a,b,c,d,e,i and `cg_o[9:6]` carries f,g,h,j, so bit 0 (a) is sent first. D21.5 at negative disparity gives 10'h155.
- R2: With `ctrl_i` = 1, the valid control characters are K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7. Each is encoded as its control code group. K28.5 at negative disparity gives 10'h17C; at positive disparity it gives 10'h283.
- R3: The running disparity resets to negative, and `disp_neg_o` reads 1 for negative. After each accepted word it becomes the disparity at the end of the code group sent. It turns positive if the group has more than five ones, turns negative if it has fewer, and is otherwise unchanged.
- R4: With `force_i` = 1, the word is encoded starting from the disparity on `dispval_i` instead of the tracked one. A `dispval_i` of 0 means positive and 1 means negative.
- R5: After a forced word, the tracked disparity follows the code group actually sent, and later unforced words continue from it.
- R6: With `polinv_i` = 1, all ten bits of `cg_o` are complemented for that word. The tracked disparity is computed from the uncomplemented group.
- R7: A word with `ctrl_i` = 1 whose byte is not a valid control character is encoded as the data byte, and `kerr_o` is 1 for that word. Otherwise `kerr_o` is 0.
- R8: Outputs are registered, with one cycle of latency. `cg_vld_o` follows `valid_i` one cycle later. While `valid_i` is 0, `cg_o` and `disp_neg_o` hold their values. After reset `cg_o` is 0 and `cg_vld_o` is 0.
- R9: Every code group emitted for a valid word has four, five or six ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | A word is presented this cycle |
| byte_i | input | 8 | Byte to encode (x = [4:0], y = [7:5]) |
| ctrl_i | input | 1 | 1 = control character, 0 = data |
| force_i | input | 1 | Take this word's starting disparity from dispval_i |
| dispval_i | input | 1 | Forced disparity: 0 positive, 1 negative |
| polinv_i | input | 1 | Complement all bits of the emitted code group |
| cg_vld_o | output | 1 | cg_o holds a newly encoded word |
| cg_o | output | 10 | Code group, bit 0 = a (sent first) |
| disp_neg_o | output | 1 | Tracked running disparity, 1 = negative |
| kerr_o | output | 1 | Last word asked for a control character that does not exist |

## Verification
The hardest situations to reach are a forced word whose disparity disagrees with the tracked one, and the alternate D.x.7 encodings that depend on the disparity left by the 5b/6b sub-block. To reach them, the stimulus draws a long random stream with occasional forcing, inversion and idle cycles. It also places directed words: K28.5 at both disparities, a forced opposite-disparity word followed by unforced ones, and x = 17 and x = 11 with y = 7 at both disparities. Every output group is checked against a bench encoder. That encoder chooses control groups from whole-character constants and decides the new disparity from the total count of ones.

// File: rtl/tx8b10b_pkg.sv
`timescale 1ns/1ps
package tx8b10b_pkg;
   localparam int BYTE_W = 8;
   localparam int X_W    = 5;
   localparam int Y_W    = BYTE_W - X_W;
   localparam int SIX_W  = X_W + 1;
   localparam int FOUR_W = Y_W + 1;
   localparam int CG_W   = SIX_W + FOUR_W;
   localparam int CG_MID = CG_W / 2;
endpackage

// File: rtl/tx8b10b_six.sv
`timescale 1ns/1ps
module tx8b10b_six
   import tx8b10b_pkg::*;
(
   input  logic [X_W-1:0]   x_i,
   input  logic             k28_i,
   input  logic             rd_pos_i,
   output logic [SIX_W-1:0] six_o,
   output logic             rd_pos_o
);
   logic [SIX_W-1:0] base;   // negative-disparity form, a at MSB
   logic [SIX_W-1:0] sent;
   logic [2:0]       ones;
   logic             unbal;
   logic             flip;

   always_comb begin
      case (x_i)
         5'd0:  base = 6'b100111;  5'd1:  base = 6'b011101;
         5'd2:  base = 6'b101101;  5'd3:  base = 6'b110001;
         5'd4:  base = 6'b110101;  5'd5:  base = 6'b101001;
         5'd6:  base = 6'b011001;  5'd7:  base = 6'b111000;
         5'd8:  base = 6'b111001;  5'd9:  base = 6'b100101;
         5'd10: base = 6'b010101;  5'd11: base = 6'b110100;
         5'd12: base = 6'b001101;  5'd13: base = 6'b101100;
         5'd14: base = 6'b011100;  5'd15: base = 6'b010111;
         5'd16: base = 6'b011011;  5'd17: base = 6'b100011;
         5'd18: base = 6'b010011;  5'd19: base = 6'b110010;
         5'd20: base = 6'b001011;  5'd21: base = 6'b101010;
         5'd22: base = 6'b011010;  5'd23: base = 6'b111010;
         5'd24: base = 6'b110011;  5'd25: base = 6'b100110;
         5'd26: base = 6'b010110;  5'd27: base = 6'b110110;
         5'd28: base = 6'b001110;  5'd29: base = 6'b101110;
         5'd30: base = 6'b011110;  default: base = 6'b101011;
      endcase
      if (k28_i) base = 6'b001111;
   end

   assign ones     = 3'($countones(base));
   assign unbal    = (ones != 3'd3);
   assign flip     = rd_pos_i & (unbal | (x_i == 5'd7));
   assign sent     = base ^ {SIX_W{flip}};
   assign rd_pos_o = rd_pos_i ^ unbal;

   for (genvar i = 0; i < SIX_W; i++) begin : g_order
      assign six_o[i] = sent[SIX_W-1-i];
   end
endmodule

// File: rtl/tx8b10b_four.sv
`timescale 1ns/1ps
module tx8b10b_four
   import tx8b10b_pkg::*;
(
   input  logic [Y_W-1:0]    y_i,
   input  logic              alt_i,
   input  logic              k28_i,
   input  logic              rd_pos_i,
   output logic [FOUR_W-1:0] four_o,
   output logic              rd_pos_o
);
   logic [FOUR_W-1:0] base;  // negative-disparity form, f at MSB
   logic [FOUR_W-1:0] sent;
   logic [2:0]        ones;
   logic              unbal;
   logic              flip;
   logic              kfix;

   always_comb begin
      case (y_i)
         3'd0:    base = 4'b1011;
         3'd1:    base = 4'b1001;
         3'd2:    base = 4'b0101;
         3'd3:    base = 4'b1100;
         3'd4:    base = 4'b1101;
         3'd5:    base = 4'b1010;
         3'd6:    base = 4'b0110;
         default: base = alt_i ? 4'b0111 : 4'b1110;
      endcase
   end

   assign ones     = 3'($countones(base));
   assign unbal    = (ones != 3'd2);
   assign flip     = rd_pos_i & (unbal | (y_i == 3'd3));
   // balanced K28 trailers take the opposite form to data after a negative 6b
   assign kfix     = k28_i & ~unbal & (y_i != 3'd3) & ~rd_pos_i;
   assign sent     = base ^ {FOUR_W{flip | kfix}};
   assign rd_pos_o = rd_pos_i ^ unbal;

   for (genvar i = 0; i < FOUR_W; i++) begin : g_order
      assign four_o[i] = sent[FOUR_W-1-i];
   end
endmodule

// File: rtl/tx8b10b_enc.sv
`timescale 1ns/1ps
module tx8b10b_enc
   import tx8b10b_pkg::*;
#(
   parameter int FORCE_EN       = 1,
   parameter int POLINV_EN      = 1,
   parameter int RESET_DISP_NEG = 1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              valid_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              ctrl_i,
   input  logic              force_i,
   input  logic              dispval_i,
   input  logic              polinv_i,
   output logic              cg_vld_o,
   output logic [CG_W-1:0]   cg_o,
   output logic              disp_neg_o,
   output logic              kerr_o
);
   localparam logic RST_RD_POS = (RESET_DISP_NEG == 0);

   if (FORCE_EN != 0 && FORCE_EN != 1) begin : g_bad_force
      $error("FORCE_EN must be 0 or 1");
   end
   if (POLINV_EN != 0 && POLINV_EN != 1) begin : g_bad_pol
      $error("POLINV_EN must be 0 or 1");
   end
   if (RESET_DISP_NEG != 0 && RESET_DISP_NEG != 1) begin : g_bad_rst
      $error("RESET_DISP_NEG must be 0 or 1");
   end

   logic [X_W-1:0]    x;
   logic [Y_W-1:0]    y;
   logic              k_ok, k_bad, k28, alt;
   logic              rd_pos_q, rd_in, rd_mid, rd_end;
   logic [SIX_W-1:0]  six;
   logic [FOUR_W-1:0] four;
   logic [CG_W-1:0]   inv_mask;
   logic              past_ok_q;

   assign x = byte_i[X_W-1:0];
   assign y = byte_i[BYTE_W-1:X_W];

   assign k_ok  = ctrl_i & ((x == 5'd28) |
                  ((y == 3'd7) & ((x == 5'd23) | (x == 5'd27) | (x == 5'd29) | (x == 5'd30))));
   assign k_bad = ctrl_i & ~k_ok;
   assign k28   = k_ok & (x == 5'd28);

   if (FORCE_EN == 1) begin : g_force
      assign rd_in = force_i ? ~dispval_i : rd_pos_q;
   end else begin : g_track
      logic unused_force;
      assign unused_force = force_i ^ dispval_i;
      assign rd_in        = rd_pos_q;
   end

   if (POLINV_EN == 1) begin : g_pol
      assign inv_mask = {CG_W{polinv_i}};
   end else begin : g_nopol
      logic unused_pol;
      assign unused_pol = polinv_i;
      assign inv_mask   = '0;
   end

   tx8b10b_six u_six (
      .x_i(x), .k28_i(k28), .rd_pos_i(rd_in), .six_o(six), .rd_pos_o(rd_mid)
   );

   assign alt = (y == 3'd7) & (k_ok |
                (~rd_mid & ((x == 5'd17) | (x == 5'd18) | (x == 5'd20))) |
                ( rd_mid & ((x == 5'd11) | (x == 5'd13) | (x == 5'd14))));

   tx8b10b_four u_four (
      .y_i(y), .alt_i(alt), .k28_i(k28), .rd_pos_i(rd_mid), .four_o(four), .rd_pos_o(rd_end)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cg_o      <= '0;
         cg_vld_o  <= 1'b0;
         kerr_o    <= 1'b0;
         rd_pos_q  <= RST_RD_POS;
         past_ok_q <= 1'b0;
      end else begin
         past_ok_q <= 1'b1;
         cg_vld_o  <= valid_i;
         if (valid_i) begin
            cg_o     <= {four, six} ^ inv_mask;
            kerr_o   <= k_bad;
            rd_pos_q <= rd_end;
         end
      end
   end

   assign disp_neg_o = ~rd_pos_q;

   a_r9_balanced: assert property (@(posedge clk_i) disable iff (rst_i)
      cg_vld_o |-> ($countones(cg_o) >= CG_MID - 1 && $countones(cg_o) <= CG_MID + 1));

   a_r3_rd_follows_group: assert property (@(posedge clk_i) disable iff (rst_i)
      past_ok_q && cg_vld_o && !(FORCE_EN == 1 && $past(force_i))
      |-> ((disp_neg_o != $past(disp_neg_o)) == ($countones(cg_o) != CG_MID)));

   a_r4_forced_positive: assert property (@(posedge clk_i) disable iff (rst_i)
      past_ok_q && cg_vld_o && FORCE_EN == 1 && $past(force_i) && !$past(dispval_i)
      && !(POLINV_EN == 1 && $past(polinv_i))
      |-> ($countones(cg_o) <= CG_MID && ($countones(cg_o) != CG_MID || !disp_neg_o)));

   a_r4_forced_negative: assert property (@(posedge clk_i) disable iff (rst_i)
      past_ok_q && cg_vld_o && FORCE_EN == 1 && $past(force_i) && $past(dispval_i)
      && !(POLINV_EN == 1 && $past(polinv_i))
      |-> ($countones(cg_o) >= CG_MID && ($countones(cg_o) != CG_MID || disp_neg_o)));

   a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
      past_ok_q && !$past(valid_i) |-> (!cg_vld_o && $stable(cg_o) && $stable(disp_neg_o)));

   a_r7_kerr_needs_ctrl: assert property (@(posedge clk_i) disable iff (rst_i)
      past_ok_q && kerr_o |-> $past(ctrl_i));
endmodule

// File: tb/tx8b10b_enc_test.sv
`timescale 1ns/1ps
module tx8b10b_enc_test;
   logic       clk = 1'b0;
   logic       rst_i = 1'b1;
   logic       valid_i = 1'b0;
   logic [7:0] byte_i = '0;
   logic       ctrl_i = 1'b0, force_i = 1'b0, dispval_i = 1'b0, polinv_i = 1'b0;
   logic       cg_vld_o, disp_neg_o, kerr_o;
   logic [9:0] cg_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tx8b10b_enc uut (
      .clk_i(clk), .rst_i(rst_i), .valid_i(valid_i), .byte_i(byte_i), .ctrl_i(ctrl_i),
      .force_i(force_i), .dispval_i(dispval_i), .polinv_i(polinv_i),
      .cg_vld_o(cg_vld_o), .cg_o(cg_o), .disp_neg_o(disp_neg_o), .kerr_o(kerr_o)
   );

   // bench model state
   logic       m_neg = 1'b1;
   bit         pend = 1'b0;
   logic [9:0] e_cg = '0;
   logic       e_neg = 1'b1, e_kerr = 1'b0, e_vld = 1'b0;
   string      e_tag = "R1", e_dtag = "R3";

   function automatic logic [5:0] t6(input logic [4:0] x);
      logic [5:0] s [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
                             6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
                             6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
                             6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
                             6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
                             6'b011110, 6'b101011};
      return s[x];
   endfunction

   function automatic logic [3:0] t4(input logic [2:0] y, input bit alt);
      logic [3:0] s [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
      if (y == 3'd7 && alt) return 4'b0111;
      return s[y];
   endfunction

   function automatic logic [3:0] k28tail(input logic [2:0] y);
      logic [3:0] s [8] = '{4'b0100, 4'b1001, 4'b0101, 4'b0011, 4'b0010, 4'b1010, 4'b0110, 4'b1000};
      return s[y];
   endfunction

   // returns code group (bit 0 = a), new negative flag, and bad-control flag
   task automatic model(input logic [7:0] b, input bit k, input bit rneg,
                        output logic [9:0] cg, output bit nneg, output bit kbad);
      logic [4:0] x = b[4:0];
      logic [2:0] y = b[7:5];
      logic [9:0] s;
      logic [5:0] p6;
      logic [3:0] p4;
      bit         sneg;
      bit         kval = (x == 28) || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30));
      int         n;
      kbad = k && !kval;
      if (k && kval) begin
         s = (x == 28) ? {6'b001111, k28tail(y)} : {t6(x), 4'b1000};
         if (!rneg) s = ~s;
      end else begin
         p6 = t6(x);
         if (!rneg && !($countones(p6) == 3 && x != 7)) p6 = ~p6;
         n = $countones(p6);
         sneg = (n > 3) ? 1'b0 : (n < 3) ? 1'b1 : rneg;
         p4 = t4(y, (sneg && (x == 17 || x == 18 || x == 20)) ||
                    (!sneg && (x == 11 || x == 13 || x == 14)));
         if (!sneg && !($countones(p4) == 2 && y != 3)) p4 = ~p4;
         s = {p6, p4};
      end
      for (int i = 0; i < 10; i++) cg[i] = s[9-i];
      n = $countones(cg);
      nneg = (n > 5) ? 1'b0 : (n < 5) ? 1'b1 : rneg;
   endtask

   task automatic check(input string tag, input string what, input logic [9:0] act, input logic [9:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic settle();
      int n;
      if (!pend) return;
      check("R8", "valid", {9'd0, cg_vld_o}, {9'd0, e_vld});
      check(e_tag, "code", cg_o, e_cg);
      check(e_dtag, "disparity", {9'd0, disp_neg_o}, {9'd0, e_neg});
      check("R7", "kerr", {9'd0, kerr_o}, {9'd0, e_kerr});
      if (e_vld) begin
         n = $countones(cg_o);
         check("R9", "ones", {9'd0, (n >= 4 && n <= 6)}, 10'd1);
      end
      pend = 1'b0;
   endtask

   task automatic word(input logic [7:0] b, input bit k, input bit f, input bit dv, input bit inv);
      logic [9:0] cg;
      bit nneg, kbad;
      @(negedge clk);
      settle();
      valid_i = 1'b1; byte_i = b; ctrl_i = k; force_i = f; dispval_i = dv; polinv_i = inv;
      model(b, k, f ? dv : m_neg, cg, nneg, kbad);
      m_neg  = nneg;
      e_cg   = inv ? ~cg : cg;
      e_neg  = nneg;
      e_kerr = kbad;
      e_vld  = 1'b1;
      e_tag  = kbad ? "R7" : inv ? "R6" : f ? "R4" : k ? "R2" : "R1";
      e_dtag = f ? "R5" : "R3";
      pend   = 1'b1;
   endtask

   task automatic idle();
      @(negedge clk);
      settle();
      valid_i = 1'b0; byte_i = 8'($urandom); ctrl_i = 1'b1; force_i = 1'b1;
      dispval_i = ~m_neg; polinv_i = 1'b1;
      e_vld = 1'b0; e_tag = "R8"; e_dtag = "R8";
      pend  = 1'b1;
   endtask

   function automatic logic [7:0] pick_k(input int r);
      logic [7:0] ks [4] = '{{3'd7, 5'd23}, {3'd7, 5'd27}, {3'd7, 5'd29}, {3'd7, 5'd30}};
      if (r % 3 == 0) return ks[(r / 3) % 4];
      return {3'((r / 3) % 8), 5'd28};
   endfunction

   initial begin
      #500us;
      if (!done) begin
         errors++; checks++;
         $display("FAIL R8 watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_i = 1'b0;
      // reset state: R3 negative disparity, R8 cleared outputs
      check("R8", "reset code", cg_o, 10'h000);
      check("R8", "reset valid", {9'd0, cg_vld_o}, 10'd0);
      check("R3", "reset disparity", {9'd0, disp_neg_o}, 10'd1);

      // R1 D21.5 at negative -> 10'h155
      word({3'd5, 5'd21}, 0, 0, 0, 0);
      @(negedge clk); settle(); valid_i = 1'b0;
      check("R1", "D21.5 literal", cg_o, 10'h155);
      // R2 K28.5 at negative -> 10'h17C, then positive -> 10'h283
      word({3'd5, 5'd28}, 1, 0, 0, 0);
      word({3'd5, 5'd28}, 1, 0, 0, 0);
      @(negedge clk); settle(); valid_i = 1'b0;
      check("R2", "K28.5 positive literal", cg_o, 10'h283);
      // R4/R5: force positive while tracked is negative, then continue unforced
      word({3'd5, 5'd28}, 1, 1, 0, 0);
      word({3'd0, 5'd0}, 0, 0, 0, 0);
      word({3'd7, 5'd7}, 0, 1, 1, 0);
      word({3'd3, 5'd3}, 0, 0, 0, 0);
      // alternate trailer cases at both disparities
      word({3'd7, 5'd17}, 0, 1, 1, 0);
      word({3'd7, 5'd17}, 0, 1, 0, 0);
      word({3'd7, 5'd11}, 0, 1, 0, 0);
      word({3'd7, 5'd11}, 0, 1, 1, 0);
      // R6 inversion, R7 bad control, R8 idle hold
      word({3'd5, 5'd28}, 1, 0, 0, 1);
      word(8'h00, 1, 0, 0, 0);
      word({3'd7, 5'd28}, 1, 0, 0, 0);
      idle(); idle();
      word({3'd1, 5'd27}, 1, 0, 0, 0);

      for (int i = 0; i < 4000; i++) begin
         int r = int'($urandom);
         if (r % 8 == 0) idle();
         else if (r % 8 == 1)
            word(((r >> 8) % 5 == 0) ? 8'(r >> 12) : pick_k(r >> 12), 1,
                 ((r >> 20) % 6) == 0, r[27], ((r >> 24) % 12) == 0);
         else
            word(8'(r >> 8), 0, ((r >> 20) % 6) == 0, r[27], ((r >> 24) % 12) == 0);
      end
      idle();
      @(negedge clk); settle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule